// File: doc/BRIEF.md
# Length-Selected Serial Register Loader

This block is the serial programming front end of a frequency synthesizer. A host shifts a bit stream into it over a three-wire synchronous port: a serial clock, a data line and an active-low enable. No address field is sent. When the enable is released, the number of bits shifted in that window decides where they go. One byte updates the configuration register. Two bytes go to the reference divider word. Three or more whole bytes go to the divider word, and only the final 24 bits are kept. The host therefore never pads the stream with dummy bits, even when several devices share one chain.

The reference and divider words are not handed to the counters the moment they arrive. Each is held in a staging register. It moves to the live output only when the counter that uses it reports a reload boundary, so a counter never sees a half-updated ratio. The configuration register can route the bit falling off the end of the shift register to a general-purpose output. That output then drives the data input of the next device in a chain.

All serial inputs are resynchronised to the system clock and edge-detected there. Bits are sampled on a rising serial clock and the chain output moves on a falling one.

Top module: `serial_reg_loader`

## Requirements
- R1: During and after reset, `cfgOut`, `refOut` and `divOut` are all zero, `refLoad`, `divLoad` and `gpOut` are low, and nothing is staged.
- R2: Exactly 8 bits in one enable window, first bit received landing in bit 7, update `cfgOut` when the enable rises, with no reload needed.
- R3: Exactly 16 bits, first bit in bit 15, are staged for the reference word. `refOut` stays unchanged until a `refReload` pulse. The cycle after that pulse is sampled, `refOut` takes the staged value and `refLoad` is high for one cycle. A `divReload` pulse does not apply the staged reference word.
- R4: 24 bits, first bit in bit 23, are staged for the divider word. The divider word is applied to `divOut` with a one-cycle `divLoad` pulse in the same way, on `divReload` only.
- R5: Any whole number of bytes of 24 bits or more targets the divider word, keeping only the last 24 bits received.
- R6: A window whose length is not a whole number of bytes, or is fewer than 8 bits, changes no register and stages nothing.
- R7: A reload pulse with nothing staged for that word gives no load strobe and leaves its output unchanged.
- R8: When `cfgOut[0]` is 1, `gpOut` carries the serial chain bit. After the k-th rising serial clock of a window (k ≥ 24), and once the following falling edge has been seen, that bit equals bit number k−23 received in the window. For k < 24 it is 0. When `cfgOut[0]` is 0, `gpOut` equals `cfgOut[1]`.
- R9: A second transfer to the same staged word before its reload replaces the first, and one reload applies only the newer value.
- R10: Serial clock edges while the enable is high shift nothing and change no output or staged state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data, sampled on rising `sclk` |
| csN | input | 1 | Active-low transfer enable; its rising edge ends a transfer |
| refReload | input | 1 | One-cycle pulse from the reference counter at its reload point |
| divReload | input | 1 | One-cycle pulse from the main and swallow counters at their reload point |
| cfgOut | output | 8 | Configuration register |
| refOut | output | 16 | Live reference divider word |
| refLoad | output | 1 | One-cycle strobe when `refOut` takes a new value |
| divOut | output | 24 | Live divider word |
| divLoad | output | 1 | One-cycle strobe when `divOut` takes a new value |
| gpOut | output | 1 | Chain data out or static level, chosen by `cfgOut[0]` |

## Verification
The bench goes after transfer lengths that sit next to a valid one: 12, 17 and 5 bits. A length decoder that rounded or truncated would write a register on these instead of dropping them. It sends 32- and 48-bit streams to the divider word. A design that kept the first bits instead of the last would show the wrong divider value. Reloads are pulsed with nothing staged, with the wrong counter's pulse, and after two back-to-back writes; these catch a design that applies early, re-applies stale data or keeps the older write. The chain output is traced bit by bit through a 32-bit window, which exposes an off-by-one delay or a shift on the wrong clock edge.

// File: rtl/slr_pkg.sv
package slr_pkg;

  // Per-cycle commands from the control unit to the datapath
  typedef struct packed {
    logic shiftIn;     // sample sdi into the shift register
    logic clearShift;  // a new enable window opened
    logic fallTick;    // serial clock fell inside the window
    logic commitCfg;   // window closed with a configuration length
    logic commitRef;   // window closed with a reference length
    logic commitDiv;   // window closed with a divider length
  } slrStrobes_t;

endpackage

// File: rtl/slr_ctrl.sv
module slr_ctrl
  import slr_pkg::*;
#(
  parameter int SyncStages = 2,
  parameter int CfgWidth   = 8,
  parameter int RefWidth   = 16,
  parameter int DivWidth   = 24,
  parameter int CntBits    = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclk,
  input  logic        sdi,
  input  logic        csN,
  output slrStrobes_t strobes,
  output logic        sdiSync
);

  localparam logic [CntBits-1:0] CfgBytes = CntBits'(CfgWidth / 8);
  localparam logic [CntBits-1:0] RefBytes = CntBits'(RefWidth / 8);
  localparam logic [CntBits-1:0] DivBytes = CntBits'(DivWidth / 8);
  localparam logic [CntBits-1:0] ByteMax  = {CntBits{1'b1}};

  logic [SyncStages-1:0] sclkPipe, sdiPipe, csPipe;
  logic sclkPrev, csPrev;
  logic sclkNow, csNow, csRise, windowOpen;
  logic [2:0] bitPhase;
  logic [CntBits-1:0] byteCnt;
  logic wholeBytes;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPipe <= '0;
      sdiPipe  <= '0;
      csPipe   <= '1;
      sclkPrev <= 1'b0;
      csPrev   <= 1'b1;
    end else begin
      sclkPipe <= {sclkPipe[SyncStages-2:0], sclk};
      sdiPipe  <= {sdiPipe[SyncStages-2:0], sdi};
      csPipe   <= {csPipe[SyncStages-2:0], csN};
      sclkPrev <= sclkNow;
      csPrev   <= csNow;
    end
  end

  assign sclkNow    = sclkPipe[SyncStages-1];
  assign csNow      = csPipe[SyncStages-1];
  assign sdiSync    = sdiPipe[SyncStages-1];
  assign windowOpen = !csNow;
  assign csRise     = !csPrev && csNow;
  assign wholeBytes = (bitPhase == 3'd0);

  always_comb begin
    strobes            = '0;
    strobes.shiftIn    = sclkNow && !sclkPrev && windowOpen;
    strobes.fallTick   = !sclkNow && sclkPrev && windowOpen;
    strobes.clearShift = csPrev && !csNow;
    strobes.commitCfg  = csRise && wholeBytes && (byteCnt == CfgBytes);
    strobes.commitRef  = csRise && wholeBytes && (byteCnt == RefBytes);
    strobes.commitDiv  = csRise && wholeBytes && (byteCnt >= DivBytes);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitPhase <= '0;
      byteCnt  <= '0;
    end else if (strobes.clearShift) begin
      bitPhase <= '0;
      byteCnt  <= '0;
    end else if (strobes.shiftIn) begin
      bitPhase <= bitPhase + 3'd1;
      if (bitPhase == 3'd7 && byteCnt != ByteMax)
        byteCnt <= byteCnt + 1'b1;
    end
  end

  // R6
  one_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.commitCfg, strobes.commitRef, strobes.commitDiv}));

  // R10
  idle_no_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(csNow) && csNow) |-> (byteCnt == $past(byteCnt) && bitPhase == $past(bitPhase)));

endmodule

// File: rtl/slr_stage.sv
module slr_stage #(
  parameter int Width = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             commit,
  input  logic [Width-1:0] din,
  input  logic             reload,
  output logic [Width-1:0] liveOut,
  output logic             loadPulse
);

  logic [Width-1:0] staged;
  logic             pending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      staged    <= '0;
      pending   <= 1'b0;
      liveOut   <= '0;
      loadPulse <= 1'b0;
    end else begin
      loadPulse <= 1'b0;
      if (reload && pending) begin
        liveOut   <= staged;
        loadPulse <= 1'b1;
        pending   <= 1'b0;
      end
      if (commit) begin
        staged  <= din;
        pending <= 1'b1;
      end
    end
  end

  // R3 R4
  load_on_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadPulse |-> $past(reload));

  // R7
  out_moves_with_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (liveOut != $past(liveOut)) |-> loadPulse);

endmodule

// File: rtl/slr_datapath.sv
module slr_datapath
  import slr_pkg::*;
#(
  parameter int CfgWidth = 8,
  parameter int RefWidth = 16,
  parameter int DivWidth = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  slrStrobes_t         strobes,
  input  logic                sdiSync,
  input  logic                refReload,
  input  logic                divReload,
  output logic [CfgWidth-1:0] cfgOut,
  output logic [RefWidth-1:0] refOut,
  output logic                refLoad,
  output logic [DivWidth-1:0] divOut,
  output logic                divLoad,
  output logic                gpOut
);

  localparam int ChainSelBit = 0;
  localparam int LevelBit    = 1;

  logic [DivWidth-1:0] shiftReg;
  logic [CfgWidth-1:0] cfgReg;
  logic                chainBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      chainBit <= 1'b0;
      cfgReg   <= '0;
    end else begin
      if (strobes.clearShift)
        shiftReg <= '0;
      else if (strobes.shiftIn)
        shiftReg <= {shiftReg[DivWidth-2:0], sdiSync};
      if (strobes.fallTick)
        chainBit <= shiftReg[DivWidth-1];
      if (strobes.commitCfg)
        cfgReg <= shiftReg[CfgWidth-1:0];
    end
  end

  slr_stage #(.Width(RefWidth)) refStage (
    .clk(clk), .rstN(rstN), .commit(strobes.commitRef),
    .din(shiftReg[RefWidth-1:0]), .reload(refReload),
    .liveOut(refOut), .loadPulse(refLoad)
  );

  slr_stage #(.Width(DivWidth)) divStage (
    .clk(clk), .rstN(rstN), .commit(strobes.commitDiv),
    .din(shiftReg), .reload(divReload),
    .liveOut(divOut), .loadPulse(divLoad)
  );

  assign cfgOut = cfgReg;
  assign gpOut  = cfgReg[ChainSelBit] ? chainBit : cfgReg[LevelBit];

  // R2
  cfg_needs_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgReg != $past(cfgReg)) |-> $past(strobes.commitCfg));

endmodule

// File: rtl/serial_reg_loader.sv
module serial_reg_loader
  import slr_pkg::*;
#(
  parameter int SyncStages = 2,
  parameter int CfgWidth   = 8,
  parameter int RefWidth   = 16,
  parameter int DivWidth   = 24,
  parameter int CntBits    = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclk,
  input  logic                sdi,
  input  logic                csN,
  input  logic                refReload,
  input  logic                divReload,
  output logic [CfgWidth-1:0] cfgOut,
  output logic [RefWidth-1:0] refOut,
  output logic                refLoad,
  output logic [DivWidth-1:0] divOut,
  output logic                divLoad,
  output logic                gpOut
);

  slrStrobes_t strobes;
  logic        sdiSync;

  slr_ctrl #(
    .SyncStages(SyncStages), .CfgWidth(CfgWidth), .RefWidth(RefWidth),
    .DivWidth(DivWidth), .CntBits(CntBits)
  ) ctrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .sdi(sdi), .csN(csN),
    .strobes(strobes), .sdiSync(sdiSync)
  );

  slr_datapath #(
    .CfgWidth(CfgWidth), .RefWidth(RefWidth), .DivWidth(DivWidth)
  ) dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .sdiSync(sdiSync),
    .refReload(refReload), .divReload(divReload),
    .cfgOut(cfgOut), .refOut(refOut), .refLoad(refLoad),
    .divOut(divOut), .divLoad(divLoad), .gpOut(gpOut)
  );

endmodule

// File: tb/serial_reg_loader_test.sv
module serial_reg_loader_test;

  localparam int ClkPeriod = 10;
  localparam int Half      = 6;
  localparam int NumVec    = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0, sdi = 1'b0, csN = 1'b1;
  logic refReload = 1'b0, divReload = 1'b0;
  logic [7:0]  cfgOut;
  logic [15:0] refOut;
  logic [23:0] divOut;
  logic refLoad, divLoad, gpOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0]  expCfg = '0;
  logic [15:0] expRef = '0, stRef = '0;
  logic [23:0] expDiv = '0, stDiv = '0;
  bit pendRef = 1'b0, pendDiv = 1'b0;

  // {length in bits, data right-aligned; data[0] is the last bit sent}
  localparam logic [55:0] VEC [NumVec] = '{
    {8'd8,  48'h0000_0000_00A6},
    {8'd16, 48'h0000_0000_1234},
    {8'd24, 48'h0000_00AB_CDEF},
    {8'd48, 48'h1111_1122_2222},
    {8'd12, 48'h0000_0000_0FFF},
    {8'd5,  48'h0000_0000_0015},
    {8'd32, 48'h0000_9944_5566},
    {8'd17, 48'h0000_0001_7777},
    {8'd8,  48'h0000_0000_005C},
    {8'd16, 48'h0000_0000_BEEF}
  };

  serial_reg_loader uut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .sdi(sdi), .csN(csN),
    .refReload(refReload), .divReload(divReload),
    .cfgOut(cfgOut), .refOut(refOut), .refLoad(refLoad),
    .divOut(divOut), .divLoad(divLoad), .gpOut(gpOut)
  );

  always #(ClkPeriod / 2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Model of the length rule, written from R2..R6 and R9
  task automatic expectXfer(input int n, input logic [47:0] d);
    if (n == 8) expCfg = d[7:0];
    else if (n == 16) begin stRef = d[15:0]; pendRef = 1'b1; end
    else if (n >= 24 && n % 8 == 0) begin stDiv = d[23:0]; pendDiv = 1'b1; end
  endtask

  task automatic sendBits(input int n, input logic [47:0] d, input bit traceChain);
    csN = 1'b0;
    waitClk(Half);
    for (int k = 1; k <= n; k++) begin
      sdi = d[n-k];
      waitClk(Half);
      sclk = 1'b1;
      waitClk(Half);
      sclk = 1'b0;
      waitClk(Half);
      if (traceChain)
        check("R8 chain bit", 32'(gpOut), (k >= 24) ? 32'(d[n-(k-23)]) : 32'd0);
    end
    waitClk(Half);
    csN = 1'b1;
    waitClk(2 * Half);
    expectXfer(n, d);
  endtask

  task automatic pulseRef(input string req);
    @(negedge clk) refReload = 1'b1;
    @(negedge clk) refReload = 1'b0;
    check({req, " refLoad"}, 32'(refLoad), 32'(pendRef));
    if (pendRef) begin expRef = stRef; pendRef = 1'b0; end
    check({req, " refOut"}, 32'(refOut), 32'(expRef));
    @(negedge clk);
    check({req, " refLoad one cycle"}, 32'(refLoad), 32'd0);
  endtask

  task automatic pulseDiv(input string req);
    @(negedge clk) divReload = 1'b1;
    @(negedge clk) divReload = 1'b0;
    check({req, " divLoad"}, 32'(divLoad), 32'(pendDiv));
    if (pendDiv) begin expDiv = stDiv; pendDiv = 1'b0; end
    check({req, " divOut"}, 32'(divOut), 32'(expDiv));
    @(negedge clk);
    check({req, " divLoad one cycle"}, 32'(divLoad), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    waitClk(3);
    // R1 during reset
    check("R1 cfg in reset", 32'(cfgOut), 32'd0);
    check("R1 gpOut in reset", 32'(gpOut), 32'd0);
    rstN = 1'b1;
    waitClk(4);
    check("R1 cfg", 32'(cfgOut), 32'd0);
    check("R1 ref", 32'(refOut), 32'd0);
    check("R1 div", 32'(divOut), 32'd0);
    check("R1 strobes", 32'({refLoad, divLoad, gpOut}), 32'd0);
    pulseRef("R1 R7 nothing staged");
    pulseDiv("R1 R7 nothing staged");

    // Table: R2 R3 R4 R5 R6
    for (int v = 0; v < NumVec; v++) begin
      sendBits(int'(VEC[v][55:48]), VEC[v][47:0], 1'b0);
      check("R2 R6 cfg after window", 32'(cfgOut), 32'(expCfg));
      check("R8 static level", 32'(gpOut), 32'(expCfg[1]));
      check("R3 ref held before reload", 32'(refOut), 32'(expRef));
      check("R4 div held before reload", 32'(divOut), 32'(expDiv));
      pulseRef("R3 R6 table");
      pulseDiv("R4 R5 R6 table");
    end

    // R3: wrong reload pulse does not apply the reference word
    sendBits(16, 48'h0F0F, 1'b0);
    pulseDiv("R3 div pulse with ref staged");
    check("R3 ref unchanged by div pulse", 32'(refOut), 32'(expRef));
    pulseRef("R3 ref applied");

    // R9: newer write replaces staged word
    sendBits(24, 48'h000001, 1'b0);
    sendBits(24, 48'h000002, 1'b0);
    pulseDiv("R9 newer wins");
    check("R9 div value", 32'(divOut), 32'h000002);
    pulseDiv("R7 second reload idle");

    // R10: serial clock with enable high
    for (int k = 0; k < 24; k++) begin
      sdi = k[0];
      waitClk(Half); sclk = 1'b1;
      waitClk(Half); sclk = 1'b0;
    end
    waitClk(2 * Half);
    check("R10 cfg unchanged", 32'(cfgOut), 32'(expCfg));
    pulseRef("R10 nothing staged");
    pulseDiv("R10 nothing staged");

    // R8: chain output
    sendBits(8, 48'h01, 1'b0);
    check("R8 chain select", 32'(cfgOut), 32'h01);
    sendBits(32, 48'hC3A5_5A0F, 1'b1);
    pulseDiv("R5 chain stream divider");
    sendBits(8, 48'h02, 1'b0);
    check("R8 level high", 32'(gpOut), 32'd1);
    sendBits(8, 48'h00, 1'b0);
    check("R8 level low", 32'(gpOut), 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule